// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This unit works on a field of a 32-bit word. A packed 10-bit control word describes the field. Its low five bits give the index of the field's lowest bit. Its upper five bits give the field width minus one. The same control word serves three operations:

- **Unsigned extract** copies the field to the bottom of the result and clears every bit above it.
- **Signed extract** copies the field the same way and fills the bits above it with the field's top bit.
- **Insert** writes the low bits of a source word into the field of a destination word and keeps the other destination bits.

An extract also updates a sign flag and a zero flag. An insert never touches the flags.

The unit has one register stage. The operation, the source, the control word and the old destination value are sampled on a rising clock edge. The result and the flags appear at the outputs just after that edge. The hold operation keeps every output as it is. A single-bit extract is the same as an extract with a width field of 0.

Top module: `bf_unit`

## Requirements
- R1: While reset is active and after reset is released, `result_o`, `sign_o` and `zero_o` are 0 until the first operation that is not a hold.
- R2: Operation code 2'b00 (hold) leaves `result_o`, `sign_o` and `zero_o` unchanged on the next clock edge.
- R3: Operation code 2'b01 (unsigned extract) returns bits [low+w−1:low] of `src_i` in bits [w−1:0] of `result_o` and zeros above them. Here low = `ctrl_i[4:0]` and w = `ctrl_i[9:5]` + 1. The result appears one clock edge after the inputs are sampled.
- R4: Operation code 2'b10 (signed extract) returns the same low w bits as R3. All bits above them take the value of `src_i` bit ((low + w − 1) mod 32).
- R5: After either extract, `sign_o` equals the fill bit used above the field, which is always 0 for an unsigned extract. `zero_o` is 1 exactly when the new `result_o` is 0.
- R6: Operation code 2'b11 (insert) with low + w ≤ 32 returns `dst_i` with bits [low+w−1:low] replaced by `src_i[w−1:0]`. All other bits equal `dst_i`.
- R7: An insert with low + w > 32 returns `dst_i` unchanged.
- R8: An insert leaves `sign_o` and `zero_o` unchanged.
- R9: A width field of 31 (w = 32) selects the whole word with no shift overflow. An extract with low = 0 then returns `src_i` unchanged, and an insert with low = 0 returns `src_i`.
- R10: For an extract whose field runs past bit 31, the missing source bits read as 0 within the low w result bits. Only the bits above w take the fill bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronized inside the unit |
| op_i | input | 2 | Operation: 00 hold, 01 unsigned extract, 10 signed extract, 11 insert |
| src_i | input | 32 | Source word |
| ctrl_i | input | 10 | Field control: [4:0] low bit index, [9:5] width minus one |
| dst_i | input | 32 | Old destination word used by insert |
| result_o | output | 32 | Registered result |
| sign_o | output | 1 | Registered sign flag, updated by extracts only |
| zero_o | output | 1 | Registered zero flag, updated by extracts only |

## Verification
Each result and flag is due exactly one rising edge after the inputs are sampled. For a hold, and for the flags after an insert, the value due is the one already on the outputs. The driver presents the inputs on a falling edge and queues the expected value at the same moment. The monitor pops one entry shortly after each following rising edge, so every comparison falls at the one cycle where the new value must be visible. The expected values come from a bit-by-bit model that keeps its own copy of the flags.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [1:0] {
    BF_HOLD   = 2'b00,
    BF_EXT_U  = 2'b01,
    BF_EXT_S  = 2'b10,
    BF_INSERT = 2'b11
  } bf_op_e;
endpackage

// File: rtl/bf_mask_gen.sv
// Builds a mask of ones over bits [wm1:0]. A per-bit compare avoids a shift by the full word width.
module bf_mask_gen #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  wm1_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask_o[i] = (IDX_W'(i) <= wm1_i);
  end
endmodule

// File: rtl/bf_extract.sv
module bf_extract #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              signed_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [IDX_W-1:0]  low_i,
  input  logic [IDX_W-1:0]  wm1_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] field_o,
  output logic              fill_o
);
  logic [DATA_W-1:0] shifted;
  logic [IDX_W-1:0]  top_idx;

  // The logical shift brings in zeros where the field runs past the top bit.
  assign shifted = src_i >> low_i;
  // The index adder wraps modulo the word width.
  assign top_idx = low_i + wm1_i;
  assign fill_o  = signed_i & src_i[top_idx];
  assign field_o = (shifted & mask_i) | ({DATA_W{fill_o}} & ~mask_i);
endmodule

// File: rtl/bf_insert.sv
module bf_insert #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [IDX_W-1:0]  low_i,
  input  logic [IDX_W-1:0]  wm1_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] result_o
);
  logic [IDX_W:0]    span;
  logic              out_of_range;
  logic [DATA_W-1:0] place;

  // low + (w - 1) reaching the word width means low + w exceeds it.
  assign span         = {1'b0, low_i} + {1'b0, wm1_i};
  assign out_of_range = span[IDX_W];
  assign place        = mask_i << low_i;

  always_comb begin
    if (out_of_range) begin
      result_o = dst_i;
    end else begin
      result_o = (dst_i & ~place) | ((src_i & mask_i) << low_i);
    end
  end
endmodule

// File: rtl/bf_unit.sv
module bf_unit #(
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int CTRL_W = 2 * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] result_o,
  output logic              sign_o,
  output logic              zero_o
);
  import bf_pkg::*;

  // The reset asserts at once and is released in step with the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Decode the operation and split the control word into its two fields.
  bf_op_e            op;
  logic [IDX_W-1:0]  low;
  logic [IDX_W-1:0]  wm1;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] ext_res;
  logic              ext_fill;
  logic [DATA_W-1:0] ins_res;

  assign op  = bf_op_e'(op_i);
  assign low = ctrl_i[IDX_W-1:0];
  assign wm1 = ctrl_i[CTRL_W-1:IDX_W];

  bf_mask_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_mask (
    .wm1_i  (wm1),
    .mask_o (mask)
  );

  bf_extract #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_extract (
    .signed_i (op == BF_EXT_S),
    .src_i    (src_i),
    .low_i    (low),
    .wm1_i    (wm1),
    .mask_i   (mask),
    .field_o  (ext_res),
    .fill_o   (ext_fill)
  );

  bf_insert #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_insert (
    .src_i    (src_i),
    .dst_i    (dst_i),
    .low_i    (low),
    .wm1_i    (wm1),
    .mask_i   (mask),
    .result_o (ins_res)
  );

  // Next state and clock enables.
  logic              res_en;
  logic              flag_en;
  logic [DATA_W-1:0] res_d;
  logic              sign_d;
  logic              zero_d;
  logic [DATA_W-1:0] res_q;
  logic              sign_q;
  logic              zero_q;

  always_comb begin
    res_en  = 1'b0;
    flag_en = 1'b0;
    res_d   = ext_res;
    sign_d  = ext_fill;
    zero_d  = (ext_res == '0);
    unique case (op)
      BF_EXT_U, BF_EXT_S: begin
        res_en  = 1'b1;
        flag_en = 1'b1;
      end
      BF_INSERT: begin
        res_en = 1'b1;
        res_d  = ins_res;
      end
      default: ;
    endcase
  end

  // Output registers.
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      sign_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      if (res_en) begin
        res_q <= res_d;
      end
      if (flag_en) begin
        sign_q <= sign_d;
        zero_q <= zero_d;
      end
    end
  end

  assign result_o = res_q;
  assign sign_o   = sign_q;
  assign zero_o   = zero_q;
endmodule

// File: rtl/bf_unit_chk.sv
module bf_unit_chk #(
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int CTRL_W = 2 * IDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] src_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] result_o,
  input logic              sign_o,
  input logic              zero_o
);
  logic ins_oor;
  logic full_low0;

  assign ins_oor   = (int'(ctrl_i[IDX_W-1:0]) + int'(ctrl_i[CTRL_W-1:IDX_W]) + 1) > DATA_W;
  assign full_low0 = (ctrl_i == {{IDX_W{1'b1}}, {IDX_W{1'b0}}});

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b00) |=> ($stable(result_o) && $stable(sign_o) && $stable(zero_o))); // R2

  AST_UNSIGNED_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01) |=> !sign_o); // R5

  AST_EXTRACT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01 || op_i == 2'b10) |=> (zero_o == (result_o == '0))); // R5

  AST_INSERT_OOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11 && ins_oor) |=> (result_o == $past(dst_i))); // R7

  AST_INSERT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11) |=> ($stable(sign_o) && $stable(zero_o))); // R8

  AST_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 2'b00 && full_low0) |=> (result_o == $past(src_i))); // R9
endmodule

bind bf_unit bf_unit_chk #(.DATA_W(DATA_W)) i_bf_unit_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_sync_n),
  .op_i     (op_i),
  .src_i    (src_i),
  .ctrl_i   (ctrl_i),
  .dst_i    (dst_i),
  .result_o (result_o),
  .sign_o   (sign_o),
  .zero_o   (zero_o)
);

// File: tb/test_bf_unit.sv
module test_bf_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  op;
  logic [31:0] src;
  logic [9:0]  ctrl;
  logic [31:0] dst;
  logic [31:0] result;
  logic        sign;
  logic        zero;

  bf_unit i_bf_unit (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .op_i     (op),
    .src_i    (src),
    .ctrl_i   (ctrl),
    .dst_i    (dst),
    .result_o (result),
    .sign_o   (sign),
    .zero_o   (zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Scoreboard queues
  logic [31:0] q_res[$];
  logic        q_sign[$];
  logic        q_zero[$];
  string       q_tag[$];

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Model state
  logic [31:0] m_res  = '0;
  logic        m_sign = 1'b0;
  logic        m_zero = 1'b0;

  function automatic logic [9:0] ctl(input int low, input int wm1);
    ctl = {wm1[4:0], low[4:0]};
  endfunction

  task automatic apply(input logic [1:0] o, input logic [31:0] s, input logic [9:0] c,
                       input logic [31:0] d, input string tag);
    int low, w;
    logic fill;
    logic [31:0] r;
    @(negedge clk);
    op = o; src = s; ctrl = c; dst = d;
    low = int'(c[4:0]);
    w   = int'(c[9:5]) + 1;
    if (o == 2'b01 || o == 2'b10) begin
      fill = (o == 2'b10) ? s[(low + w - 1) % 32] : 1'b0;
      for (int i = 0; i < 32; i++) begin
        if (i < w) r[i] = (low + i < 32) ? s[low + i] : 1'b0;
        else       r[i] = fill;
      end
      m_res = r; m_sign = fill; m_zero = (r == 32'h0);
    end else if (o == 2'b11) begin
      if (low + w > 32) begin
        r = d;
      end else begin
        for (int i = 0; i < 32; i++) begin
          r[i] = (i >= low && i < low + w) ? s[i - low] : d[i];
        end
      end
      m_res = r;
    end
    q_res.push_back(m_res);
    q_sign.push_back(m_sign);
    q_zero.push_back(m_zero);
    q_tag.push_back(tag);
  endtask

  // Monitor: each vector is due one rising edge after it is driven.
  always @(posedge clk) begin
    #1;
    if (q_res.size() > 0) begin
      logic [31:0] er;
      logic es, ez;
      string t;
      er = q_res.pop_front();
      es = q_sign.pop_front();
      ez = q_zero.pop_front();
      t  = q_tag.pop_front();
      n_vec++;
      if (result !== er || sign !== es || zero !== ez) begin
        n_fail++;
        $display("FAIL %s: result=%h sign=%b zero=%b expected result=%h sign=%b zero=%b",
                 t, result, sign, zero, er, es, ez);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: result=%h expected completion", result);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    op = 2'b00; src = '0; ctrl = '0; dst = '0;
    #1;
    n_vec++;
    if (result !== 32'h0 || sign !== 1'b0 || zero !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 in reset: result=%h sign=%b zero=%b expected 0 0 0", result, sign, zero);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: outputs zero after release, checked through hold vectors
    apply(2'b00, 32'hFFFF_FFFF, ctl(3, 5), 32'h1234_5678, "R1");
    apply(2'b00, 32'h0, ctl(0, 0), 32'h0, "R1");

    // R3 unsigned extract
    apply(2'b01, 32'hDEAD_BEEF, ctl(4, 7), 32'h0, "R3");
    // R4 signed extract, negative field
    apply(2'b10, 32'hDEAD_BEEF, ctl(4, 7), 32'h0, "R4");
    // R2 hold keeps result and flags
    apply(2'b00, 32'h5555_5555, ctl(1, 1), 32'h0, "R2");
    // R4 signed extract, positive field
    apply(2'b10, 32'h0000_0007, ctl(0, 3), 32'h0, "R4");
    // R5 zero flag on an empty field
    apply(2'b01, 32'hFFFF_00FF, ctl(8, 7), 32'h0, "R5");
    // R5 single-bit signed extract of a 1 gives all ones and sign set
    apply(2'b10, 32'h0000_0100, ctl(8, 0), 32'h0, "R5");
    // R9 full-width extracts
    apply(2'b01, 32'h8000_0001, ctl(0, 31), 32'h0, "R9");
    apply(2'b10, 32'h8000_0001, ctl(0, 31), 32'h0, "R9");
    // R10 field past bit 31
    apply(2'b01, 32'hF000_0000, ctl(28, 7), 32'h0, "R10");
    apply(2'b10, 32'hF000_0008, ctl(28, 7), 32'h0, "R10");
    // R6 insert
    apply(2'b11, 32'hFFFF_FFAB, ctl(8, 7), 32'h1122_3344, "R6");
    apply(2'b11, 32'h0000_0003, ctl(24, 7), 32'h0000_0000, "R6");
    // R9 full-width insert
    apply(2'b11, 32'hCAFE_F00D, ctl(0, 31), 32'h1111_1111, "R9");
    // R7 out-of-range inserts
    apply(2'b11, 32'hFFFF_FFFF, ctl(28, 7), 32'h0BAD_C0DE, "R7");
    apply(2'b11, 32'hFFFF_FFFF, ctl(1, 31), 32'h1357_9BDF, "R7");
    // R8 flags untouched by insert, then a hold
    apply(2'b01, 32'h0, ctl(0, 3), 32'h0, "R8");
    apply(2'b11, 32'hFFFF_FFFF, ctl(0, 3), 32'h0, "R8");
    apply(2'b00, 32'h0, ctl(0, 0), 32'h0, "R8");

    // Mixed random vectors
    for (int k = 0; k < 400; k++) begin
      logic [1:0] ro;
      ro = 2'($urandom_range(0, 3));
      apply(ro, $urandom, 10'($urandom), $urandom,
            (ro == 2'b00) ? "R2" : (ro == 2'b01) ? "R3" : (ro == 2'b10) ? "R4" : "R6");
    end

    @(negedge clk);
    op = 2'b00;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule